// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block places one received Ethernet frame at a time into system memory. Software prepares a list of four-word receive descriptors. Each descriptor carries an ownership flag, two buffer lengths and two addresses. The descriptors are laid out either back to back or linked through their fourth word, and a ring can be closed back to a programmed list base. The block owns a single 32-bit memory master port. It uses that port to fetch descriptors, to store frame bytes into buffer 1 and, when the descriptor is not chained, into buffer 2. It also uses the port to return the descriptor to software with its first/last flags and the frame length filled in.

A frame is offered through a request handshake that carries its byte length and a sideband copy of its destination address. Its bytes then follow on a valid/ready byte stream. Frames that are too short, that are addressed to another station, or that find no descriptor owned by the block are consumed from the byte stream and discarded. A missing descriptor also bumps a saturating drop counter. A completed frame produces a one-cycle completion pulse and a sticky pending flag. No new frame is accepted while that flag is set, and the flag is cleared by a clear input.

The control is a single state machine with these states:
- ST_IDLE: waits for a frame request. It goes to ST_CHECK on acceptance.
- ST_CHECK: applies the filter. It goes to ST_RD_W0 if the frame passes, otherwise to ST_DISCARD.
- ST_RD_W0: reads word 0. It goes to ST_RD_W1 if the descriptor is owned by the block, otherwise to ST_DISCARD.
- ST_RD_W1, ST_RD_W2, ST_RD_W3: read the remaining three words, in that order.
- ST_FILL1: fills buffer 1. It goes to ST_FILL2 when bytes remain and the descriptor is unchained, otherwise to ST_WBACK.
- ST_FILL2: fills buffer 2, then goes to ST_WBACK.
- ST_WBACK: writes word 0 back, then goes to ST_NEXT.
- ST_NEXT: advances the pointer. It goes to ST_IDLE when the frame is complete, otherwise to ST_RD_W0.
- ST_DISCARD: drains the remaining bytes, then goes to ST_IDLE.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset the descriptor pointer and drop counter are zero, nothing is pending, no memory request is made and a frame request is accepted at once.
- R2: A write to the list base register loads base and descriptor pointer with the value's two low bits forced to zero, visible the next cycle.
- R3: A frame is written only if its destination equals {station high, station low} (destination bits [7:0] = first byte on the wire = station low bits [7:0]; station high holds bytes 5 and 4) or is all ones. Any other frame has all its bytes consumed and causes no memory write.
- R4: A frame shorter than 14 bytes is consumed and causes no memory write, even when broadcast.
- R5: Descriptor words are read at pointer+0, +4, +8, +12. Word 0 bit 31 set means the block owns the descriptor, word 2 is the buffer 1 address and word 3 is the buffer 2 or link address.
- R6: Frame bytes fill buffer 1 (length = word 1 bits [12:0]) and then, only if word 1 bit 14 (chained) is clear and bytes remain, buffer 2 (length = word 1 bits [28:16]), at consecutive byte addresses.
- R7: Write-back stores word 0 at the pointer with bit 31 cleared, bit 9 set only on the frame's first descriptor, bit 8 set only on its last, bits [29:16] = frame length on the last descriptor, and all other bits unchanged.
- R8: After write-back the pointer becomes the list base if chained and word 1 bit 15 (end of ring) is set, word 3 with bits [1:0] cleared if chained only, else pointer+16.
- R9: A completed frame gives a one-cycle completion pulse and sets the pending flag. The flag stays set until the clear input, and no frame request is accepted meanwhile.
- R10: If the descriptor at the pointer is not owned (at frame start or mid-frame), the drop counter increments (saturating), the rest of the frame is consumed without writes, no completion occurs and the pointer stays.
- R11: Each frame byte is one memory write to the aligned word address, with a one-hot byte enable for lane address[1:0] and the byte repeated in all four lanes. Write-back uses all four enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr_i | input | 1 | List base register write strobe |
| base_i | input | ADDR_W | List base write value |
| sta_hi_i | input | 16 | Station address bytes 5 and 4 |
| sta_lo_i | input | 32 | Station address bytes 3 to 0 |
| frm_valid_i | input | 1 | Frame request |
| frm_ready_o | output | 1 | Frame request accepted |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_dst_i | input | 48 | Destination address, first byte in bits [7:0] |
| byte_valid_i | input | 1 | Frame byte valid |
| byte_data_i | input | 8 | Frame byte |
| byte_ready_o | output | 1 | Frame byte taken |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rx_done_o | output | 1 | Frame completion pulse |
| rx_pend_o | output | 1 | Completion pending |
| rx_clr_i | input | 1 | Clear pending completion |
| drop_cnt_o | output | CNT_W | Frames dropped for lack of a descriptor |
| desc_ptr_o | output | ADDR_W | Current descriptor pointer |

## Verification
The frame request is accepted in the same cycle it is offered from ST_IDLE, and a byte is taken in the same cycle as its memory write is acknowledged. A base write shows on the pointer one cycle later. The completion pulse rises in the cycle after the write-back is acknowledged, and the pending flag follows one cycle after that. The bench drives inputs on falling edges and samples one nanosecond later. Every memory write is compared, in the cycle it is presented, against the head of a queue built by a behavioural model of the descriptor walk. Pointer, pending flag, drop counter and completion count are checked ten cycles after the last byte, which is well past the two states that follow the final byte.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    // Descriptor field positions (shared with software)
    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;
    localparam int CHAIN_BIT = 14;
    localparam int EOR_BIT   = 15;
    localparam int BLEN_W    = 13;
    localparam int B1_LSB    = 0;
    localparam int B2_LSB    = 16;
    localparam int FLEN_LSB  = 16;
    localparam int FLEN_W    = 14;
    localparam int MIN_FRAME = 14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_W0,
        ST_RD_W1,
        ST_RD_W2,
        ST_RD_W3,
        ST_FILL1,
        ST_FILL2,
        ST_WBACK,
        ST_NEXT,
        ST_DISCARD
    } rxdw_state_e;

endpackage

// File: rtl/rxdw_addr_filter.sv
module rxdw_addr_filter #(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 14
) (
    input  logic [47:0]      dst_i,
    input  logic [15:0]      sta_hi_i,
    input  logic [31:0]      sta_lo_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             accept_o
);
    localparam int NBYTES = 6;

    logic [47:0]       station;
    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_bc;

    assign station = {sta_hi_i, sta_lo_i};

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign byte_eq[k] = (dst_i[8*k +: 8] == station[8*k +: 8]);
        assign byte_bc[k] = (dst_i[8*k +: 8] == 8'hFF);
    end

    assign accept_o = ((&byte_eq) || (&byte_bc)) && (len_i >= LEN_W'(MIN_LEN));
endmodule

// File: rtl/rxdw_ptr_unit.sv
module rxdw_ptr_unit #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              adv_i,
    input  logic              chained_i,
    input  logic              eor_i,
    input  logic [ADDR_W-1:0] link_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(3);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_next;

    always_comb begin
        if (chained_i) ptr_next = eor_i ? base_q : (link_i & ALIGN);
        else           ptr_next = ptr_q + ADDR_W'(STRIDE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (base_wr_i) begin
            base_q <= base_i & ALIGN;
            ptr_q  <= base_i & ALIGN;
        end else if (adv_i) begin
            ptr_q  <= ptr_next;
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/rxdw_byte_lane.sv
module rxdw_byte_lane #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lane_i,
    input  logic [7:0]               data_i,
    output logic [LANES-1:0]         be_o,
    output logic [8*LANES-1:0]       wdata_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign be_o[k]          = (lane_i == k[$clog2(LANES)-1:0]);
        assign wdata_o[8*k +: 8] = data_i;
    end
endmodule

// File: rtl/rxdw_sat_counter.sv
module rxdw_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (inc_i && (cnt_q != '1)) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
    import rxdw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 14,
    parameter int CNT_W      = 8,
    parameter int DESC_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [15:0]       sta_hi_i,
    input  logic [31:0]       sta_lo_i,
    input  logic              frm_valid_i,
    output logic              frm_ready_o,
    input  logic [LEN_W-1:0]  frm_len_i,
    input  logic [47:0]       frm_dst_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    output logic              byte_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              rx_done_o,
    output logic              rx_pend_o,
    input  logic              rx_clr_i,
    output logic [CNT_W-1:0]  drop_cnt_o,
    output logic [ADDR_W-1:0] desc_ptr_o
);
    localparam int WORD_BYTES = 4;
    localparam int STRIDE     = DESC_WORDS * WORD_BYTES;

    rxdw_state_e state_q, state_d;

    logic [31:0]       w0_q, w1_q, w2_q, w3_q;
    logic [LEN_W-1:0]  len_q, rem_q;
    logic [47:0]       dst_q;
    logic [BLEN_W-1:0] bcnt_q;
    logic              first_q, pend_q;

    logic              accept;
    logic              adv, cnt_inc;
    logic [ADDR_W-1:0] ptr;
    logic [BLEN_W-1:0] buf1_len, buf2_len, fill_len;
    logic              chained, eor, last, fill_go, in_fill, byte_take;
    logic [ADDR_W-1:0] buf_base, byte_addr;
    logic [3:0]        lane_be;
    logic [31:0]       lane_data, wb_word;

    assign buf1_len  = w1_q[B1_LSB +: BLEN_W];
    assign buf2_len  = w1_q[B2_LSB +: BLEN_W];
    assign chained   = w1_q[CHAIN_BIT];
    assign eor       = w1_q[EOR_BIT];
    assign last      = (rem_q == '0);
    assign in_fill   = (state_q == ST_FILL1) || (state_q == ST_FILL2);
    assign fill_len  = (state_q == ST_FILL1) ? buf1_len : buf2_len;
    assign buf_base  = (state_q == ST_FILL1) ? ADDR_W'(w2_q) : ADDR_W'(w3_q);
    assign byte_addr = buf_base + ADDR_W'(bcnt_q);
    assign fill_go   = (bcnt_q != fill_len) && !last;
    assign byte_take = in_fill && fill_go && byte_valid_i && mem_ack_i;

    rxdw_addr_filter #(.LEN_W(LEN_W), .MIN_LEN(MIN_FRAME)) u_filter (
        .dst_i    (dst_q),
        .sta_hi_i (sta_hi_i),
        .sta_lo_i (sta_lo_i),
        .len_i    (len_q),
        .accept_o (accept)
    );

    rxdw_ptr_unit #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr_i (base_wr_i),
        .base_i    (base_i),
        .adv_i     (adv),
        .chained_i (chained),
        .eor_i     (eor),
        .link_i    (ADDR_W'(w3_q)),
        .ptr_o     (ptr)
    );

    rxdw_byte_lane #(.LANES(WORD_BYTES)) u_lane (
        .lane_i  (byte_addr[1:0]),
        .data_i  (byte_data_i),
        .be_o    (lane_be),
        .wdata_o (lane_data)
    );

    rxdw_sat_counter #(.CNT_W(CNT_W)) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (cnt_inc),
        .cnt_o (drop_cnt_o)
    );

    // Returned word 0
    always_comb begin
        wb_word            = w0_q;
        wb_word[OWN_BIT]   = 1'b0;
        wb_word[FIRST_BIT] = first_q;
        wb_word[LAST_BIT]  = last;
        if (last) wb_word[FLEN_LSB +: FLEN_W] = FLEN_W'(len_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d      = state_q;
        frm_ready_o  = 1'b0;
        byte_ready_o = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        mem_be_o     = 4'h0;
        mem_wdata_o  = '0;
        rx_done_o    = 1'b0;
        adv          = 1'b0;
        cnt_inc      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                frm_ready_o = !pend_q;
                if (frm_valid_i && !pend_q) state_d = ST_CHECK;
            end
            ST_CHECK: state_d = accept ? ST_RD_W0 : ST_DISCARD;
            ST_RD_W0: begin
                mem_req_o  = 1'b1;
                mem_be_o   = 4'hF;
                mem_addr_o = ptr;
                if (mem_ack_i) begin
                    if (mem_rdata_i[OWN_BIT]) state_d = ST_RD_W1;
                    else begin
                        cnt_inc = 1'b1;
                        state_d = ST_DISCARD;
                    end
                end
            end
            ST_RD_W1: begin
                mem_req_o  = 1'b1;
                mem_be_o   = 4'hF;
                mem_addr_o = ptr + ADDR_W'(4);
                if (mem_ack_i) state_d = ST_RD_W2;
            end
            ST_RD_W2: begin
                mem_req_o  = 1'b1;
                mem_be_o   = 4'hF;
                mem_addr_o = ptr + ADDR_W'(8);
                if (mem_ack_i) state_d = ST_RD_W3;
            end
            ST_RD_W3: begin
                mem_req_o  = 1'b1;
                mem_be_o   = 4'hF;
                mem_addr_o = ptr + ADDR_W'(12);
                if (mem_ack_i) state_d = ST_FILL1;
            end
            ST_FILL1, ST_FILL2: begin
                if (fill_go) begin
                    mem_req_o    = byte_valid_i;
                    mem_we_o     = 1'b1;
                    mem_addr_o   = {byte_addr[ADDR_W-1:2], 2'b00};
                    mem_be_o     = lane_be;
                    mem_wdata_o  = lane_data;
                    byte_ready_o = byte_take;
                end else if (state_q == ST_FILL1 && !last && !chained) begin
                    state_d = ST_FILL2;
                end else begin
                    state_d = ST_WBACK;
                end
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_be_o    = 4'hF;
                mem_addr_o  = ptr;
                mem_wdata_o = wb_word;
                if (mem_ack_i) state_d = ST_NEXT;
            end
            ST_NEXT: begin
                adv = 1'b1;
                if (last) begin
                    rx_done_o = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    state_d   = ST_RD_W0;
                end
            end
            ST_DISCARD: begin
                if (last) state_d = ST_IDLE;
                else      byte_ready_o = byte_valid_i;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q    <= '0;
            w1_q    <= '0;
            w2_q    <= '0;
            w3_q    <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            dst_q   <= '0;
            bcnt_q  <= '0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && frm_valid_i && !pend_q) begin
                len_q   <= frm_len_i;
                rem_q   <= frm_len_i;
                dst_q   <= frm_dst_i;
                first_q <= 1'b1;
            end
            if (mem_ack_i && state_q == ST_RD_W0) w0_q <= mem_rdata_i;
            if (mem_ack_i && state_q == ST_RD_W1) w1_q <= mem_rdata_i;
            if (mem_ack_i && state_q == ST_RD_W2) w2_q <= mem_rdata_i;
            if (mem_ack_i && state_q == ST_RD_W3) begin
                w3_q   <= mem_rdata_i;
                bcnt_q <= '0;
            end
            if (in_fill) begin
                if (byte_take) begin
                    bcnt_q <= bcnt_q + BLEN_W'(1);
                    rem_q  <= rem_q - LEN_W'(1);
                end else if (!fill_go) begin
                    bcnt_q <= '0;
                end
            end
            if (state_q == ST_DISCARD && byte_ready_o) rem_q <= rem_q - LEN_W'(1);
            if (state_q == ST_NEXT) first_q <= 1'b0;
            if (state_q == ST_NEXT && last) pend_q <= 1'b1;
            else if (rx_clr_i)              pend_q <= 1'b0;
        end
    end

    assign rx_pend_o  = pend_q;
    assign desc_ptr_o = ptr;
endmodule

// File: rtl/rxdw_checker.sv
module rxdw_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_ready_o,
    input logic              rx_pend_o,
    input logic              rx_clr_i,
    input logic              rx_done_o,
    input logic [CNT_W-1:0]  drop_cnt_o,
    input logic [ADDR_W-1:0] desc_ptr_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [3:0]        mem_be_o
);
    a_r9_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend_o |-> !frm_ready_o);

    a_r9_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pend_o && !rx_clr_i) |=> rx_pend_o);

    a_r9_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |=> rx_pend_o);

    a_r2_ptr_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ptr_o[1:0] == 2'b00);

    a_r10_drop_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> drop_cnt_o >= $past(drop_cnt_o));

    a_r11_byte_write_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_be_o != 4'hF) |-> $onehot(mem_be_o));
endmodule

bind rx_desc_writer rxdw_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rxdw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_ready_o (frm_ready_o),
    .rx_pend_o   (rx_pend_o),
    .rx_clr_i    (rx_clr_i),
    .rx_done_o   (rx_done_o),
    .drop_cnt_o  (drop_cnt_o),
    .desc_ptr_o  (desc_ptr_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o)
);

// File: tb/rx_desc_writer_test.sv
module rx_desc_writer_test;
    localparam int MEMW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_v = '0;
    logic [15:0] sta_hi = 16'hA1B2;
    logic [31:0] sta_lo = 32'hC3D4E5F6;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [13:0] frm_len = '0;
    logic [47:0] frm_dst = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;
    logic        rx_done, rx_pend;
    logic        rx_clr = 1'b0;
    logic [7:0]  drop_cnt;
    logic [31:0] desc_ptr;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    bit finished = 0;

    logic [31:0] mem [MEMW];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    logic [3:0]  q_be   [$];
    logic [31:0] mptr = '0;
    logic [31:0] mbase = '0;
    int          mcnt = 0;
    int          exp_done = 0;
    bit          exp_pend = 0;

    localparam logic [47:0] STATION = 48'hA1B2C3D4E5F6;
    localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;

    always #2 clk = ~clk;

    assign mem_ack = mem_req;

    rx_desc_writer uut (
        .clk(clk), .rst_n(rst_n), .base_wr_i(base_wr), .base_i(base_v),
        .sta_hi_i(sta_hi), .sta_lo_i(sta_lo),
        .frm_valid_i(frm_valid), .frm_ready_o(frm_ready), .frm_len_i(frm_len), .frm_dst_i(frm_dst),
        .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_ready_o(byte_ready),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .rx_done_o(rx_done), .rx_pend_o(rx_pend), .rx_clr_i(rx_clr),
        .drop_cnt_o(drop_cnt), .desc_ptr_o(desc_ptr)
    );

    function automatic int widx(input logic [31:0] a);
        return int'((a >> 2) & 32'(MEMW - 1));
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // memory model: read data settles at the falling edge, writes land at the rising edge
    always @(negedge clk) mem_rdata <= mem[widx(mem_addr)];

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[widx(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // per-cycle comparison of every write against the model's queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) done_seen++;
            if (mem_req && mem_we) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R3/R11 unexpected memory write", longint'(mem_addr), 0);
                end else begin
                    logic [31:0] ea, ed;
                    logic [3:0]  eb;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    eb = q_be.pop_front();
                    chk(mem_addr == ea, "R6/R11 write address", longint'(mem_addr), longint'(ea));
                    chk(mem_be == eb, "R11 write byte enables", longint'(mem_be), longint'(eb));
                    chk(mem_wdata == ed, "R7/R11 write data", longint'(mem_wdata), longint'(ed));
                end
            end
        end
    end

    task automatic push_byte(input logic [31:0] a, input logic [7:0] b);
        q_addr.push_back({a[31:2], 2'b00});
        q_be.push_back(4'b0001 << a[1:0]);
        q_data.push_back({4{b}});
    endtask

    // behavioural model of one frame's descriptor walk
    task automatic model_frame(input int len, input logic [47:0] dst, input int seed);
        int rem, pos, guard;
        bit first;
        logic [31:0] p, w0, w1, w2, w3, wb;
        int l1, l2, n;
        exp_done = 0;
        if (!(dst == STATION || dst == BCAST) || len < 14) return;
        rem = len; pos = 0; first = 1; p = mptr; guard = 0;
        while (guard < 64) begin
            guard++;
            w0 = mem[widx(p)]; w1 = mem[widx(p + 4)];
            w2 = mem[widx(p + 8)]; w3 = mem[widx(p + 12)];
            if (!w0[31]) begin
                if (mcnt < 255) mcnt++;
                break;
            end
            l1 = int'(w1[12:0]); l2 = int'(w1[28:16]);
            n = (l1 < rem) ? l1 : rem;
            for (int i = 0; i < n; i++) push_byte(w2 + 32'(i), 8'(seed + pos + i));
            pos += n; rem -= n;
            if (rem > 0 && !w1[14]) begin
                n = (l2 < rem) ? l2 : rem;
                for (int i = 0; i < n; i++) push_byte(w3 + 32'(i), 8'(seed + pos + i));
                pos += n; rem -= n;
            end
            wb = w0; wb[31] = 1'b0; wb[9] = first; wb[8] = (rem == 0);
            if (rem == 0) wb[29:16] = 14'(len);
            q_addr.push_back(p); q_be.push_back(4'hF); q_data.push_back(wb);
            if (w1[14]) p = w1[15] ? mbase : (w3 & ~32'd3);
            else        p = p + 32'd16;
            mptr = p;
            if (rem == 0) begin
                exp_done = 1;
                exp_pend = 1;
                break;
            end
            first = 0;
        end
    endtask

    task automatic send_frame(input int len, input logic [47:0] dst, input int seed);
        model_frame(len, dst, seed);
        done_seen = 0;
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 14'(len); frm_dst = dst;
        forever begin
            #1;
            if (frm_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        frm_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            byte_valid = 1'b1; byte_data = 8'(seed + i);
            forever begin
                #1;
                if (byte_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
        end
        byte_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic frame_checks(input string tag);
        #1;
        chk(q_addr.size() == 0, {tag, " all expected writes issued"}, q_addr.size(), 0);
        chk(desc_ptr == mptr, {tag, " R8 descriptor pointer"}, longint'(desc_ptr), longint'(mptr));
        chk(rx_pend == exp_pend, {tag, " R9 pending flag"}, rx_pend, exp_pend);
        chk(int'(drop_cnt) == mcnt, {tag, " R10 drop counter"}, drop_cnt, mcnt);
        chk(done_seen == exp_done, {tag, " R9 completion pulses"}, done_seen, exp_done);
    endtask

    task automatic clear_pend();
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
        exp_pend = 0;
        #1;
        chk(rx_pend == 1'b0, "R9 pending cleared", rx_pend, 0);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[widx(a)] = w0; mem[widx(a + 4)] = w1;
        mem[widx(a + 8)] = w2; mem[widx(a + 12)] = w3;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEMW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(desc_ptr == 0, "R1 pointer after reset", desc_ptr, 0);
        chk(drop_cnt == 0, "R1 drop counter after reset", drop_cnt, 0);
        chk(rx_pend == 0 && mem_req == 0, "R1 idle outputs", {rx_pend, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(frm_ready == 1, "R1 ready after reset", frm_ready, 1);

        // R2 base write drops the low bits
        @(negedge clk); base_wr = 1'b1; base_v = 32'h0000_1003;
        @(negedge clk); base_wr = 1'b0; #1;
        chk(desc_ptr == 32'h1000, "R2 base alignment", desc_ptr, 32'h1000);
        mptr = 32'h1000; mbase = 32'h1000;

        // descriptor images
        put_desc(32'h1000, 32'h8000_0040, (32'd16 << 16) | 32'd8, 32'h2000, 32'h2100);
        put_desc(32'h1010, 32'h8000_0000, (32'd1 << 14) | 32'd10, 32'h2200, 32'h0000_1102);
        put_desc(32'h1100, 32'h8000_0000, (32'd12 << 16) | 32'd12, 32'h2301, 32'h2402);
        put_desc(32'h1110, 32'h8000_0000, (32'd1 << 15) | (32'd1 << 14) | 32'd64, 32'h2500, 32'h3333);

        // R5 R6 R7 R8: unchained descriptor, both buffers, station match
        send_frame(20, STATION, 8'h10);
        frame_checks("F1 unchained");

        // R9: held while pending
        @(negedge clk); frm_valid = 1'b1; frm_len = 14'd30; frm_dst = BCAST;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk(frm_ready == 0 && mem_req == 0, "R9 frame held while pending", {frm_ready, mem_req}, 0);
            @(negedge clk);
        end
        frm_valid = 1'b0;
        clear_pend();

        // R6 R8: chained link with unaligned low bits, broadcast, two descriptors, unaligned buffers
        send_frame(30, BCAST, 8'h40);
        frame_checks("F2 chained");
        clear_pend();

        // R3: foreign destination
        send_frame(20, 48'hA1B2C3D4E5F7, 8'h70);
        frame_checks("F3 R3 foreign destination");

        // R4: short broadcast frame
        send_frame(13, BCAST, 8'h80);
        frame_checks("F4 R4 short frame");

        // R8: chained with end of ring returns to base
        send_frame(40, STATION, 8'h90);
        frame_checks("F5 end of ring");
        clear_pend();

        // R10: descriptor at base now belongs to software
        send_frame(20, STATION, 8'hA0);
        frame_checks("F6 R10 no descriptor");

        // R10: descriptor runs out mid-frame
        put_desc(32'h1000, 32'h8000_0000, (32'd8 << 16) | 32'd8, 32'h2600, 32'h2700);
        send_frame(30, STATION, 8'hB0);
        frame_checks("F7 R10 mid-frame");

        #1;
        chk(mem[widx(32'h1000)][31] == 0, "R7 ownership returned", mem[widx(32'h1000)][31], 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule